// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block is a half-duplex synchronous serial port that moves one frame at a time through a single shift register. The port itself produces the shift clock. A small host register window holds four registers: a control register, a data register (writes go to the transmit buffer, reads return the receive buffer), a status register and a shift-clock divisor.

A write to the transmit buffer queues a frame. When the transfer is allowed to start, the frame moves into the shifter and goes out least significant bit first. Data changes while the shift clock is low, and the receiver samples on the rising shift-clock edge. If clear-to-send gating is switched on, a queued frame waits until the clear-to-send input is seen high. That input is asynchronous: it is captured on the rising system-clock edge and handed to the transfer logic on the next falling edge. It is never latched, so only its live level counts once a frame is waiting.

Software starts a reception by setting the receive-enable bit. The setting is refused while the receive-complete flag is still set. When the frame is complete, the received byte goes to the receive buffer, the flag is raised and receive-enable drops back to 0.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the status register reads 0x03 (bit0 transmit-buffer-free = 1, bit1 all-empty = 1, bit2 receive-complete = 0). The control register reads 0, the divisor reads 3, `sclk_o` is 1 and `sdata_oe` is 0.
- R2: A write to register 1 in shift mode (control bits [2:0] = 000) sends the byte LSB first on `sdata_o`, with `sdata_oe` = 1, over eight shift-clock periods. `sclk_o` idles high. Data is stable at each rising `sclk_o` edge. Each low or high half of `sclk_o` lasts divisor+1 system clocks.
- R3: Status bit0 reads 0 from the write of register 1 until the byte enters the shifter on the following clock. Status bit1 clears on that write and sets only after the last bit has been shifted out.
- R4: With control bit3 (CTS gating) set, a queued byte does not start while `cts_i` is low. It starts once `cts_i` is held high for two clock cycles.
- R5: A `cts_i` pulse that ends before register 1 is written does not start that transfer. The byte stays queued (status bit0 = 0, `sclk_o` high) until `cts_i` is high again.
- R6: Setting control bit4 (receive enable) starts eight shift-clock periods with `sdata_oe` = 0, sampling `sdata_i` LSB first on rising `sclk_o`. At the end the byte reads back from register 1, status bit2 is 1 and control bit4 reads 0.
- R7: While status bit2 is 1, a write that sets control bit4 is refused (bit4 reads 0 and no shift clock runs). Writing 1 to status bit2 clears the flag.
- R8: Status bits [7:3] (error and break flags) always read 0 in this mode.
- R9: Control bit5 (break) forces `sdata_o` low with `sdata_oe` = 1, whatever the mode field holds. Clearing it restores the idle line (`sdata_o` = 1, `sdata_oe` = 0).
- R10: With control bits [2:0] other than 000, no transfer starts and a queued byte stays queued. The byte is sent once the field is set back to 000.
- R11: If a reception completes in the same clock edge as a write of 1 to status bit2, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 data, 2 status, 3 divisor |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cts_i | input | 1 | Asynchronous clear-to-send, active high |
| sclk_o | output | 1 | Generated shift clock, idles high |
| sdata_o | output | 1 | Serial data out |
| sdata_oe | output | 1 | Output enable for the data pin |
| sdata_i | input | 1 | Serial data in |

## Verification
The collision of interest is the end of a reception and a software clear of the receive-complete flag landing on the same clock edge. The bench provokes it by counting shift-clock rising edges during a reception. After the eighth rise it waits exactly divisor system clocks, so that its write-one-to-clear is sampled on the edge where the frame completes. It then expects the flag to read 1 and the received byte to be intact. A second clear one cycle later must bring the flag to 0.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_DATA = 2'd1,
      A_STAT = 2'd2,
      A_DIV  = 2'd3
   } ssp_addr_e;

   // control register bit positions
   localparam int CB_CTS  = 3;
   localparam int CB_RXEN = 4;
   localparam int CB_BRK  = 5;

   // status register bit positions
   localparam int SB_FREE   = 0;
   localparam int SB_EMPTY  = 1;
   localparam int SB_RXDONE = 2;
endpackage

// File: rtl/ssp_cts_sync.sv
module ssp_cts_sync #(
   parameter bit NEG_HANDOFF = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage1 <= 1'b0;
      else        stage1 <= async_in;
   end

   generate
      if (NEG_HANDOFF) begin : g_neg
         // second stage on the falling edge: half-cycle handoff
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) sync_out <= 1'b0;
            else        sync_out <= stage1;
         end
      end else begin : g_pos
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_out <= 1'b0;
            else        sync_out <= stage1;
         end
      end
   endgenerate
endmodule

// File: rtl/ssp_half_timer.sv
module ssp_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= div;
      else if (run) begin
         if (cnt == '0)    cnt <= div;
         else              cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/ssp_shift_engine.sv
module ssp_shift_engine #(
   parameter int FRAME_W = 8,
   parameter int DIV_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_tx,
   input  logic               start_rx,
   input  logic [FRAME_W-1:0] tx_word,
   input  logic [DIV_W-1:0]   div,
   input  logic               sdi,
   output logic               busy,
   output logic               is_tx,
   output logic               sclk,
   output logic               sdo,
   output logic [FRAME_W-1:0] word,
   output logic               done
);
   localparam int CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

   logic             tick, phase_hi, start;
   logic [CNT_W-1:0] bitcnt;
   logic [FRAME_W-1:0] sh;

   assign start = start_tx | start_rx;
   assign done  = tick && phase_hi && (bitcnt == LAST);
   assign sdo   = sh[0];
   assign word  = sh;

   ssp_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(start), .run(busy), .div(div), .tick(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         is_tx    <= 1'b0;
         sclk     <= 1'b1;
         phase_hi <= 1'b0;
         bitcnt   <= '0;
         sh       <= '0;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            is_tx    <= start_tx;
            sclk     <= 1'b0;
            phase_hi <= 1'b0;
            bitcnt   <= '0;
            sh       <= start_tx ? tx_word : '0;
         end
      end else if (tick) begin
         if (!phase_hi) begin
            sclk     <= 1'b1;
            phase_hi <= 1'b1;
            if (!is_tx) sh <= {sdi, sh[FRAME_W-1:1]};
         end else if (bitcnt == LAST) begin
            busy <= 1'b0;
         end else begin
            sclk     <= 1'b0;
            phase_hi <= 1'b0;
            bitcnt   <= bitcnt + 1'b1;
            if (is_tx) sh <= {1'b0, sh[FRAME_W-1:1]};
         end
      end
   end

   p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk);
   p_sdo_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_tx && $rose(sclk)) |-> $stable(sdo));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
   parameter int         HOST_W      = 8,
   parameter int         FRAME_W     = 8,
   parameter int         DIV_W       = 8,
   parameter logic [2:0] SHIFT_MODE  = 3'b000,
   parameter int         DIV_RESET   = 3,
   parameter bit         CTS_NEG_HANDOFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [HOST_W-1:0] wdata,
   output logic [HOST_W-1:0] rdata,
   input  logic              cts_i,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              sdata_oe,
   input  logic              sdata_i
);
   import ssp_pkg::*;

   if (FRAME_W < 2 || FRAME_W > HOST_W) begin : g_bad_frame
      $error("FRAME_W must lie between 2 and HOST_W");
   end
   if (HOST_W < 6) begin : g_bad_host
      $error("HOST_W must hold the control fields");
   end
   if (DIV_W < 1 || DIV_W > HOST_W) begin : g_bad_div
      $error("DIV_W must lie between 1 and HOST_W");
   end
   if (DIV_RESET < 0 || DIV_RESET >= (1 << DIV_W)) begin : g_bad_divrst
      $error("DIV_RESET does not fit DIV_W");
   end

   logic [MODE_W-1:0]  mode;
   logic               cts_en, rx_en, brk;
   logic [FRAME_W-1:0] tx_buf, rx_buf, eng_word;
   logic [DIV_W-1:0]   div;
   logic               tx_pend, all_empty, rx_done;
   logic               cts_s, busy, is_tx, sclk, sdo, done;
   logic               wr_ctrl, wr_data, wr_stat, wr_div;
   logic               mode_ok, go_tx, go_rx, rx_fin, tx_fin;

   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_data = wr_en && (addr == A_DATA);
   assign wr_stat = wr_en && (addr == A_STAT);
   assign wr_div  = wr_en && (addr == A_DIV);

   assign mode_ok = (mode == SHIFT_MODE);
   assign go_tx   = tx_pend && !busy && mode_ok && (!cts_en || cts_s);
   assign go_rx   = !go_tx && rx_en && !rx_done && !busy && mode_ok;
   assign rx_fin  = done && !is_tx;
   assign tx_fin  = done && is_tx;

   ssp_cts_sync #(.NEG_HANDOFF(CTS_NEG_HANDOFF)) u_cts (
      .clk(clk), .rst_n(rst_n), .async_in(cts_i), .sync_out(cts_s)
   );

   ssp_shift_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start_tx(go_tx), .start_rx(go_rx),
      .tx_word(tx_buf), .div(div), .sdi(sdata_i), .busy(busy), .is_tx(is_tx),
      .sclk(sclk), .sdo(sdo), .word(eng_word), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= '0;
         cts_en <= 1'b0;
         brk    <= 1'b0;
         div    <= DIV_W'(DIV_RESET);
         tx_buf <= '0;
      end else begin
         if (wr_ctrl) begin
            mode   <= wdata[MODE_W-1:0];
            cts_en <= wdata[CB_CTS];
            brk    <= wdata[CB_BRK];
         end
         if (wr_div)  div    <= wdata[DIV_W-1:0];
         if (wr_data) tx_buf <= wdata[FRAME_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_pend   <= 1'b0;
         all_empty <= 1'b1;
      end else begin
         if (wr_data)    tx_pend <= 1'b1;
         else if (go_tx) tx_pend <= 1'b0;
         if (wr_data)                 all_empty <= 1'b0;
         else if (tx_fin && !tx_pend) all_empty <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en   <= 1'b0;
         rx_done <= 1'b0;
         rx_buf  <= '0;
      end else begin
         if (rx_fin)       rx_en <= 1'b0;
         else if (wr_ctrl) rx_en <= wdata[CB_RXEN] && !rx_done;
         if (rx_fin)                           rx_done <= 1'b1;
         else if (wr_stat && wdata[SB_RXDONE]) rx_done <= 1'b0;
         if (rx_fin) rx_buf <= eng_word;
      end
   end

   always_comb begin
      rdata = '0;
      case (ssp_addr_e'(addr))
         A_CTRL: rdata = HOST_W'({brk, rx_en, cts_en, mode});
         A_DATA: rdata = HOST_W'(rx_buf);
         A_STAT: rdata = HOST_W'({rx_done, all_empty, !tx_pend});
         A_DIV:  rdata = HOST_W'(div);
         default: rdata = '0;
      endcase
   end

   assign sclk_o   = sclk;
   assign sdata_o  = brk ? 1'b0 : ((busy && is_tx) ? sdo : 1'b1);
   assign sdata_oe = brk | (busy && is_tx);

   p_cts_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && is_tx && $past(cts_en)) |-> $past(cts_s));
   p_free_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && is_tx && !$past(wr_data)) |-> !tx_pend);
   p_empty_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      all_empty |-> !(busy && is_tx));
   p_rx_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !is_tx) |-> $past(!rx_done));
   p_rx_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !is_tx) |-> (rx_done && !rx_en));
   p_done_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !is_tx && $past(wr_stat && wdata[SB_RXDONE])) |-> rx_done);
   p_brk_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> (sdata_oe && !sdata_o));
   p_mode_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mode_ok));
endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       cts_i = 1'b0;
   logic       sclk_o, sdata_o, sdata_oe;
   logic       sdata_i = 1'b1;

   int tests = 0;
   int fails = 0;
   int cur_div = 3;

   always #10 clk = ~clk;

   sync_shift_port u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cts_i(cts_i), .sclk_o(sclk_o), .sdata_o(sdata_o),
      .sdata_oe(sdata_oe), .sdata_i(sdata_i)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; write is sampled on the next rising edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic set_div(input int d);
      cur_div = d;
      wr(2'd3, 8'(d));
   endtask

   task automatic cap_tx(output logic [7:0] b, output int low0, output bit oe_ok);
      oe_ok = 1'b1;
      for (int i = 0; i < 8; i++) begin
         int lc;
         while (sclk_o) @(negedge clk);
         lc = 0;
         while (!sclk_o) begin lc++; @(negedge clk); end
         if (i == 0) low0 = lc;
         b[i] = sdata_o;
         if (!sdata_oe) oe_ok = 1'b0;
      end
      repeat (cur_div + 3) @(negedge clk);
   endtask

   task automatic run_rx(input logic [7:0] b, input bit collide, output bit oe_ok);
      oe_ok = 1'b1;
      wr(2'd0, 8'h10);
      for (int i = 0; i < 8; i++) begin
         while (sclk_o) @(negedge clk);
         sdata_i = b[i];
         while (!sclk_o) begin
            if (sdata_oe) oe_ok = 1'b0;
            @(negedge clk);
         end
      end
      if (collide) begin
         repeat (cur_div) @(negedge clk);
         wr(2'd2, 8'h04);
      end else begin
         repeat (cur_div + 2) @(negedge clk);
      end
      sdata_i = 1'b1;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(2'd2, v);
      chk(v == 8'h03, "R1 status", v, 8'h03);
      chk(v[7:3] == 0, "R8 flags at reset", v[7:3], 0);
      rd(2'd0, v);
      chk(v == 8'h00, "R1 ctrl", v, 0);
      rd(2'd3, v);
      chk(v == 8'd3, "R1 div", v, 3);
      chk(sclk_o == 1'b1 && sdata_oe == 1'b0, "R1 lines", {sclk_o, sdata_oe}, 2'b10);
   endtask

   task automatic t_tx(input logic [7:0] b, input int d);
      logic [7:0] got, v;
      int low0;
      bit oe_ok;
      set_div(d);
      wr(2'd1, b);
      rd(2'd2, v);
      chk(v[0] == 1'b0 && v[1] == 1'b0, "R3 flags after write", v[1:0], 0);
      @(negedge clk);
      rd(2'd2, v);
      chk(v[0] == 1'b1 && v[1] == 1'b0, "R3 free after load", v[1:0], 1);
      cap_tx(got, low0, oe_ok);
      chk(got == b, "R2 tx byte", got, b);
      chk(low0 == d + 1, "R2 half period", low0, d + 1);
      chk(oe_ok, "R2 oe during tx", oe_ok, 1);
      rd(2'd2, v);
      chk(v[1:0] == 2'b11, "R3 empty after tx", v[1:0], 3);
   endtask

   task automatic t_cts_block();
      logic [7:0] got, v;
      int low0;
      bit oe_ok;
      set_div(2);
      wr(2'd0, 8'h08);
      wr(2'd1, 8'h5A);
      repeat (30) @(negedge clk);
      rd(2'd2, v);
      chk(sclk_o == 1'b1 && v[0] == 1'b0, "R4 held without cts", {sclk_o, v[0]}, 2'b10);
      cts_i = 1'b1;
      repeat (2) @(negedge clk);
      cts_i = 1'b0;
      cap_tx(got, low0, oe_ok);
      chk(got == 8'h5A, "R4 tx after cts", got, 8'h5A);
   endtask

   task automatic t_cts_unlatched();
      logic [7:0] got, v;
      int low0;
      bit oe_ok;
      cts_i = 1'b1;
      repeat (3) @(negedge clk);
      cts_i = 1'b0;
      repeat (3) @(negedge clk);
      wr(2'd1, 8'hE1);
      repeat (30) @(negedge clk);
      rd(2'd2, v);
      chk(sclk_o == 1'b1 && v[0] == 1'b0, "R5 early pulse ignored", {sclk_o, v[0]}, 2'b10);
      cts_i = 1'b1;
      cap_tx(got, low0, oe_ok);
      cts_i = 1'b0;
      chk(got == 8'hE1, "R5 tx after live cts", got, 8'hE1);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_rx();
      logic [7:0] v;
      bit oe_ok;
      set_div(2);
      run_rx(8'h96, 1'b0, oe_ok);
      chk(oe_ok, "R6 oe low during rx", oe_ok, 1);
      rd(2'd1, v);
      chk(v == 8'h96, "R6 rx byte", v, 8'h96);
      rd(2'd2, v);
      chk(v[2] == 1'b1, "R6 rx done", v[2], 1);
      chk(v[7:3] == 0, "R8 flags after rx", v[7:3], 0);
      rd(2'd0, v);
      chk(v[4] == 1'b0, "R6 rx enable cleared", v[4], 0);
   endtask

   task automatic t_rx_blocked();
      logic [7:0] v;
      bit moved = 1'b0;
      wr(2'd0, 8'h10);
      rd(2'd0, v);
      chk(v[4] == 1'b0, "R7 enable refused", v[4], 0);
      for (int i = 0; i < 20; i++) begin
         if (!sclk_o) moved = 1'b1;
         @(negedge clk);
      end
      chk(!moved, "R7 no shift clock", moved, 0);
      wr(2'd2, 8'h04);
      rd(2'd2, v);
      chk(v[2] == 1'b0, "R7 flag cleared", v[2], 0);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      bit oe_ok;
      set_div(3);
      run_rx(8'h3B, 1'b1, oe_ok);
      rd(2'd2, v);
      chk(v[2] == 1'b1, "R11 set wins over clear", v[2], 1);
      rd(2'd1, v);
      chk(v == 8'h3B, "R11 rx byte", v, 8'h3B);
      wr(2'd2, 8'h04);
      rd(2'd2, v);
      chk(v[2] == 1'b0, "R11 later clear", v[2], 0);
   endtask

   task automatic t_mode();
      logic [7:0] got, v;
      int low0;
      bit oe_ok;
      set_div(1);
      wr(2'd0, 8'h01);
      wr(2'd1, 8'hC3);
      repeat (30) @(negedge clk);
      rd(2'd2, v);
      chk(sclk_o == 1'b1 && v[0] == 1'b0, "R10 held in other mode", {sclk_o, v[0]}, 2'b10);
      wr(2'd0, 8'h00);
      cap_tx(got, low0, oe_ok);
      chk(got == 8'hC3, "R10 tx after mode", got, 8'hC3);
   endtask

   task automatic t_brk();
      wr(2'd0, 8'h22);
      chk(sdata_o == 1'b0 && sdata_oe == 1'b1, "R9 break drives low", {sdata_o, sdata_oe}, 2'b01);
      wr(2'd0, 8'h00);
      chk(sdata_o == 1'b1 && sdata_oe == 1'b0, "R9 break released", {sdata_o, sdata_oe}, 2'b10);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx(8'hA5, 3);
      t_tx(8'h3C, 0);
      t_cts_block();
      t_cts_unlatched();
      t_rx();
      t_rx_blocked();
      t_collide();
      t_mode();
      t_brk();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule